// File: doc/BRIEF.md
# Multichannel Conversion Sequencer

This block controls an external successive-approximation converter. It talks to the converter over a plain handshake. It raises a one-cycle start strobe with a channel number. It then waits for a done strobe, which carries a 12-bit sample and an error bit. The block holds the most recent sample and the error state. It also presents each completed sample, with its error bit, on a one-cycle strobe for a downstream result queue.

Software sets an enable, a 3-bit channel field and a 5-bit mask with one bit per input. A single-shot request runs one conversion. A single-shot request made during a busy conversion is held until the converter is free. A continuous-run level keeps conversions going. Each continuous conversion is paced by a fractional divisor with a 16-bit whole part and an 8-bit fraction. When the mask is nonzero, the channel steps to the next enabled input after every conversion.

Top module: `conv_sequencer`

## Requirements
- R1: After reset the block is in this state: the start strobe is low, the queue strobe is low, the sample is 0, both error flags are 0, the channel is 0 and ready is 0.
- R2: While the enable is 0, no start strobe is raised and the converter clock enable is 0. A single-shot request made while disabled is discarded, and nothing starts when the enable later returns.
- R3: A single-shot request produces exactly one start strobe, one cycle wide. The strobe appears two cycles after the request cycle when the converter is idle.
- R4: A single-shot request made while a conversion is in flight is held. It starts a second conversion once the first completes.
- R5: Ready is 1 exactly when the enable is 1 and no conversion is in flight.
- R6: A done strobe during a conversion makes the queue strobe high for one cycle, on the next cycle. Along with it, the captured 12-bit sample appears on both the sample output and the queue data output.
- R7: The latest-error flag and the queue error bit equal the error bit of the most recent conversion only.
- R8: The sticky error flag sets on any errored conversion and holds until a clear pulse (write-one) arrives. An error that arrives in the same cycle as a clear takes priority.
- R9: After each conversion with a nonzero mask, the channel moves to the lowest set mask bit above the current channel. If there is none, it moves to the lowest set bit overall. A zero mask leaves the channel unchanged. A software channel write loads the field directly.
- R10: In continuous mode, successive starts are 1 + whole + carry cycles apart. The carry comes from an 8-bit fraction accumulator that begins at 0. For example, whole 3 and fraction 128 gives 4,5,4,5. Whole 5 and fraction 64 gives 6,6,6,7. Starts stop once the continuous level drops.
- R11: With a zero divisor and a one-cycle converter, continuous conversions run back to back, one start every 3 cycles.
- R12: A done strobe while no conversion is in flight is ignored. No queue strobe is raised and the held sample does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Converter interface enable |
| cfg_chan_wr | input | 1 | Load pulse for the channel field |
| cfg_chan_wdata | input | 3 | Channel value to load |
| cfg_chan_mask | input | 5 | Round-robin mask, one bit per input |
| start_once | input | 1 | Single-shot request pulse |
| run_continuous | input | 1 | Continuous conversion level |
| div_int | input | 16 | Pacing divisor, whole part |
| div_frac | input | 8 | Pacing divisor, fraction in 1/256 |
| sticky_clr | input | 1 | Write-one clear of the sticky error |
| conv_clk_en | output | 1 | Converter power and clock enable |
| conv_start | output | 1 | Start strobe to the converter |
| conv_chan | output | 3 | Channel presented to the converter (current channel field) |
| conv_done | input | 1 | Completion strobe from the converter |
| conv_result | input | 12 | Sample from the converter |
| conv_err | input | 1 | Error bit from the converter |
| ready | output | 1 | Idle and able to start |
| result | output | 12 | Most recent sample |
| err_last | output | 1 | Error of the most recent conversion |
| err_sticky | output | 1 | Sticky error flag |
| q_valid | output | 1 | Sample strobe to the result queue |
| q_data | output | 12 | Sample to the result queue |
| q_err | output | 1 | Error bit to the result queue |

## Verification
Some properties are checked by assertions on every cycle:
- the start strobe is a single cycle wide and only starts while enabled;
- ready is never high alongside a start;
- the sticky flag cannot drop without a clear;
- each channel step lands on a set mask bit;
- a stray done strobe never reaches the queue.

Other behaviours can only be shown by the bench's scenarios, because each spans many cycles:
- the exact spacing of paced starts, including the alternating fractional periods;
- the channel order over a full scan;
- the hold of a single-shot request made while busy;
- the discarding of a request made while disabled.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int NCH    = 5;
  localparam int CH_W   = 3;
  localparam int RES_W  = 12;
  localparam int INT_W  = 16;
  localparam int FRAC_W = 8;

  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} seq_state_e;

  // lowest set mask bit above cur, else lowest set bit, else cur
  function automatic logic [CH_W-1:0] next_channel(input logic [CH_W-1:0] cur,
                                                   input logic [NCH-1:0]  mask);
    logic [CH_W-1:0] res;
    logic            found;
    res   = cur;
    found = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (!found && mask[i] && (CH_W'(i) > cur)) begin
        res   = CH_W'(i);
        found = 1'b1;
      end
    end
    for (int i = 0; i < NCH; i++) begin
      if (!found && mask[i]) begin
        res   = CH_W'(i);
        found = 1'b1;
      end
    end
    return res;
  endfunction

  // fraction accumulate: {carry, new accumulator}
  function automatic logic [FRAC_W:0] pace_step(input logic [FRAC_W-1:0] acc,
                                                input logic [FRAC_W-1:0] frac);
    return {1'b0, acc} + {1'b0, frac};
  endfunction
endpackage

// File: rtl/seq_chan_rotator.sv
module seq_chan_rotator
  import seq_pkg::*;
#(
  parameter int N_CH  = NCH,
  parameter int C_W   = CH_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [C_W-1:0]  wdata,
  input  logic [N_CH-1:0] mask,
  input  logic            adv,
  output logic [C_W-1:0]  chan
);
  logic [C_W-1:0] chan_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   chan_q <= '0;
    else if (wr)  chan_q <= wdata;
    else if (adv) chan_q <= next_channel(chan_q, mask);
  end

  assign chan = chan_q;

  // R9
  rotate_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr && (mask != '0)) |=> ((($past(mask) >> chan_q) & N_CH'(1)) == N_CH'(1)));
  // R9
  zero_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr && (mask == '0)) |=> $stable(chan_q));
endmodule

// File: rtl/seq_pacer.sv
module seq_pacer
  import seq_pkg::*;
#(
  parameter int I_W = INT_W,
  parameter int F_W = FRAC_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           active,
  input  logic [I_W-1:0] div_int,
  input  logic [F_W-1:0] div_frac,
  output logic           tick
);
  localparam int CNT_W = I_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [F_W-1:0]   acc_q;
  logic [F_W:0]     step;

  assign step = pace_step(acc_q, div_frac);
  assign tick = active && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (!active) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (tick) begin
      cnt_q <= CNT_W'(div_int) + CNT_W'(step[F_W]);
      acc_q <= step[F_W-1:0];
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R10
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (div_int != '0)) |=> !tick);
endmodule

// File: rtl/seq_capture.sv
module seq_capture
  import seq_pkg::*;
#(
  parameter int R_W = RES_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cap,
  input  logic [R_W-1:0] din,
  input  logic           err_in,
  input  logic           sticky_clr,
  output logic [R_W-1:0] sample,
  output logic           err_last,
  output logic           err_sticky,
  output logic           strobe
);
  logic [R_W-1:0] sample_q;
  logic           last_q, sticky_q, strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q <= '0;
      last_q   <= 1'b0;
      sticky_q <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= cap;
      if (cap) begin
        sample_q <= din;
        last_q   <= err_in;
      end
      if (cap && err_in)   sticky_q <= 1'b1;
      else if (sticky_clr) sticky_q <= 1'b0;
    end
  end

  assign sample     = sample_q;
  assign err_last   = last_q;
  assign err_sticky = sticky_q;
  assign strobe     = strobe_q;

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sticky && !sticky_clr) |=> err_sticky);
  // R7
  err_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (err_last == $past(err_in)));
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import seq_pkg::*;
#(
  parameter int N_CH = NCH,
  parameter int C_W  = CH_W,
  parameter int R_W  = RES_W,
  parameter int I_W  = INT_W,
  parameter int F_W  = FRAC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_enable,
  input  logic            cfg_chan_wr,
  input  logic [C_W-1:0]  cfg_chan_wdata,
  input  logic [N_CH-1:0] cfg_chan_mask,
  input  logic            start_once,
  input  logic            run_continuous,
  input  logic [I_W-1:0]  div_int,
  input  logic [F_W-1:0]  div_frac,
  input  logic            sticky_clr,
  output logic            conv_clk_en,
  output logic            conv_start,
  output logic [C_W-1:0]  conv_chan,
  input  logic            conv_done,
  input  logic [R_W-1:0]  conv_result,
  input  logic            conv_err,
  output logic            ready,
  output logic [R_W-1:0]  result,
  output logic            err_last,
  output logic            err_sticky,
  output logic            q_valid,
  output logic [R_W-1:0]  q_data,
  output logic            q_err
);
  seq_state_e state_q;
  logic       once_pend_q, pace_pend_q, start_q;
  logic       busy, done_evt, launch, pace_tick, pace_active;

  assign busy        = (state_q == ST_BUSY);
  assign done_evt    = cfg_enable && busy && conv_done;
  assign launch      = cfg_enable && !busy && (once_pend_q || pace_pend_q);
  assign pace_active = cfg_enable && run_continuous;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      once_pend_q <= 1'b0;
      pace_pend_q <= 1'b0;
      start_q     <= 1'b0;
    end else if (!cfg_enable) begin
      state_q     <= ST_IDLE;
      once_pend_q <= 1'b0;
      pace_pend_q <= 1'b0;
      start_q     <= 1'b0;
    end else begin
      start_q     <= launch;
      if (launch)        state_q <= ST_BUSY;
      else if (done_evt) state_q <= ST_IDLE;
      once_pend_q <= (once_pend_q && !launch) || start_once;
      pace_pend_q <= run_continuous && ((pace_pend_q && !launch) || pace_tick);
    end
  end

  seq_pacer #(.I_W(I_W), .F_W(F_W)) u_pacer (
    .clk(clk), .rst_n(rst_n), .active(pace_active),
    .div_int(div_int), .div_frac(div_frac), .tick(pace_tick)
  );

  seq_chan_rotator #(.N_CH(N_CH), .C_W(C_W)) u_rot (
    .clk(clk), .rst_n(rst_n), .wr(cfg_chan_wr), .wdata(cfg_chan_wdata),
    .mask(cfg_chan_mask), .adv(done_evt), .chan(conv_chan)
  );

  seq_capture #(.R_W(R_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap(done_evt), .din(conv_result),
    .err_in(conv_err), .sticky_clr(sticky_clr), .sample(result),
    .err_last(err_last), .err_sticky(err_sticky), .strobe(q_valid)
  );

  assign conv_clk_en = cfg_enable;
  assign conv_start  = start_q;
  assign ready       = cfg_enable && !busy;
  assign q_data      = result;
  assign q_err       = err_last;

  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  // R2
  start_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(cfg_enable));
  // R5
  ready_not_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !conv_start);
  // R12
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !busy) |=> !q_valid);
  // R6
  q_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |=> !q_valid);
endmodule

// File: tb/conv_sequencer_tb.sv
module conv_sequencer_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0] ch;
    logic [4:0] mask;
    logic       err;
    logic [2:0] nxt;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd0, 5'b00110, 1'b0, 3'd1},
    '{3'd1, 5'b00110, 1'b1, 3'd2},
    '{3'd2, 5'b00110, 1'b0, 3'd1},
    '{3'd4, 5'b00001, 1'b0, 3'd0},
    '{3'd3, 5'b00000, 1'b1, 3'd3},
    '{3'd3, 5'b01000, 1'b0, 3'd3},
    '{3'd6, 5'b10100, 1'b0, 3'd2},
    '{3'd4, 5'b11111, 1'b0, 3'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_enable = 0, cfg_chan_wr = 0, start_once = 0, run_continuous = 0, sticky_clr = 0;
  logic [2:0] cfg_chan_wdata = '0;
  logic [4:0] cfg_chan_mask = '0;
  logic [15:0] div_int = '0;
  logic [7:0] div_frac = '0;
  logic conv_clk_en, conv_start, ready, err_last, err_sticky, q_valid, q_err;
  logic [2:0] conv_chan;
  logic [11:0] result, q_data;
  logic conv_done, conv_err;
  logic [11:0] conv_result;

  int total = 0, bad = 0;

  // converter model
  int lat = 1;
  int mcnt = 0;
  logic done_m = 0, err_m = 0, err_sel = 0, force_done = 0;
  logic [11:0] res_m = '0, force_res = '0;

  assign conv_done   = done_m | force_done;
  assign conv_result = force_done ? force_res : res_m;
  assign conv_err    = force_done ? 1'b0 : err_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_chan_wr(cfg_chan_wr),
    .cfg_chan_wdata(cfg_chan_wdata), .cfg_chan_mask(cfg_chan_mask),
    .start_once(start_once), .run_continuous(run_continuous),
    .div_int(div_int), .div_frac(div_frac), .sticky_clr(sticky_clr),
    .conv_clk_en(conv_clk_en), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_done(conv_done), .conv_result(conv_result), .conv_err(conv_err),
    .ready(ready), .result(result), .err_last(err_last), .err_sticky(err_sticky),
    .q_valid(q_valid), .q_data(q_data), .q_err(q_err)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      done_m <= 1'b0;
      mcnt   <= 0;
    end else if (conv_start) begin
      done_m <= (lat == 1);
      mcnt   <= lat - 1;
      res_m  <= {conv_chan, 9'h0C3};
      err_m  <= err_sel;
    end else if (mcnt > 0) begin
      mcnt   <= mcnt - 1;
      done_m <= (mcnt == 1);
    end else begin
      done_m <= 1'b0;
    end
  end

  // monitor
  int cyc = 0, nst = 0, nq = 0;
  int st_time [64];
  logic [2:0] st_chan [64];
  always @(posedge clk) begin
    cyc++;
    if (conv_start && nst < 64) begin
      st_time[nst] = cyc;
      st_chan[nst] = conv_chan;
      nst++;
    end
    if (q_valid) nq++;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_once = 1'b1;
    @(negedge clk);
    start_once = 1'b0;
  endtask

  task automatic wait_q();
    for (int k = 0; k < 40; k++) begin
      if (q_valid) break;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int base, sum, prev;
    logic [11:0] held;
    logic [2:0] scan [3];
    scan = '{3'd0, 3'd2, 3'd4};
    tick(3);
    // R1 reset state
    check(conv_start == 0 && q_valid == 0, "R1 strobes", conv_start + q_valid, 0);
    check(result == 0 && err_last == 0 && err_sticky == 0, "R1 data", int'(result), 0);
    check(conv_chan == 0 && ready == 0, "R1 chan/ready", int'(conv_chan) + ready, 0);
    rst_n = 1'b1;
    tick(2);

    // R2 disabled: request discarded
    pulse_start();
    tick(8);
    check(nst == 0 && conv_clk_en == 0, "R2 disabled", nst, 0);
    check(ready == 0, "R5 ready low when disabled", ready, 0);
    cfg_enable = 1'b1;
    tick(6);
    check(nst == 0, "R2 dropped request", nst, 0);
    check(ready == 1 && conv_clk_en == 1, "R5 ready when idle", ready, 1);

    // R3 single shot timing
    base = nst;
    start_once = 1'b1;
    @(negedge clk);
    start_once = 1'b0;
    @(negedge clk);
    check(conv_start == 1, "R3 start two cycles after request", conv_start, 1);
    tick(6);
    check(nst == base + 1, "R3 exactly one start", nst - base, 1);

    // vector table: R6 R7 R9
    for (int v = 0; v < 8; v++) begin
      cfg_chan_wr = 1'b1;
      cfg_chan_wdata = VECS[v].ch;
      cfg_chan_mask = VECS[v].mask;
      err_sel = VECS[v].err;
      @(negedge clk);
      cfg_chan_wr = 1'b0;
      pulse_start();
      wait_q();
      check(q_valid == 1 && q_data == {VECS[v].ch, 9'h0C3}, "R6 queue sample",
            int'(q_data), int'({VECS[v].ch, 9'h0C3}));
      check(result == {VECS[v].ch, 9'h0C3}, "R6 held sample", int'(result),
            int'({VECS[v].ch, 9'h0C3}));
      check(err_last == VECS[v].err && q_err == VECS[v].err, "R7 latest error",
            err_last, VECS[v].err);
      check(conv_chan == VECS[v].nxt, "R9 next channel", int'(conv_chan), int'(VECS[v].nxt));
      @(negedge clk);
      check(q_valid == 0, "R6 strobe one cycle", q_valid, 0);
    end

    // R8 sticky
    check(err_sticky == 1 && err_last == 0, "R8 sticky held", err_sticky, 1);
    sticky_clr = 1'b1;
    @(negedge clk);
    sticky_clr = 1'b0;
    check(err_sticky == 0, "R8 sticky cleared", err_sticky, 0);

    // R12 stray done
    held = result;
    base = nq;
    force_res = 12'hFFF;
    force_done = 1'b1;
    @(negedge clk);
    force_done = 1'b0;
    tick(3);
    check(nq == base && result == held, "R12 stray done ignored", int'(result), int'(held));

    // R4 request while busy
    lat = 5;
    cfg_chan_mask = '0;
    base = nst;
    prev = nq;
    pulse_start();
    for (int k = 0; k < 10; k++) begin
      if (conv_start) break;
      @(negedge clk);
    end
    @(negedge clk);
    check(ready == 0, "R5 ready low while busy", ready, 0);
    pulse_start();
    tick(25);
    check(nst == base + 2, "R4 held request started", nst - base, 2);
    check(nq == prev + 2, "R4 two samples", nq - prev, 2);

    // R10 pacing 3 + 128/256, with R9 scan order
    lat = 1;
    cfg_chan_mask = 5'b10101;
    cfg_chan_wr = 1'b1;
    cfg_chan_wdata = 3'd0;
    @(negedge clk);
    cfg_chan_wr = 1'b0;
    div_int = 16'd3;
    div_frac = 8'd128;
    base = nst;
    run_continuous = 1'b1;
    for (int k = 0; k < 200; k++) begin
      if (nst >= base + 9) break;
      @(negedge clk);
    end
    run_continuous = 1'b0;
    sum = st_time[base+8] - st_time[base];
    check(sum == 36, "R10 paced span 3.5", sum, 36);
    for (int i = 0; i < 8; i++) begin
      prev = st_time[base+i+1] - st_time[base+i];
      check(prev == ((i % 2 == 0) ? 4 : 5), "R10 paced interval", prev, (i % 2 == 0) ? 4 : 5);
    end
    for (int i = 0; i < 9; i++)
      check(st_chan[base+i] == scan[i % 3], "R9 scan order", int'(st_chan[base+i]),
            int'(scan[i % 3]));
    tick(10);
    prev = nst;
    tick(20);
    check(nst == prev, "R10 stops when level drops", nst, prev);

    // R10 pacing 5 + 64/256
    div_int = 16'd5;
    div_frac = 8'd64;
    base = nst;
    run_continuous = 1'b1;
    for (int k = 0; k < 200; k++) begin
      if (nst >= base + 5) break;
      @(negedge clk);
    end
    run_continuous = 1'b0;
    check(st_time[base+4] - st_time[base] == 25, "R10 paced span 5.25",
          st_time[base+4] - st_time[base], 25);
    check(st_time[base+4] - st_time[base+3] == 7, "R10 carry period",
          st_time[base+4] - st_time[base+3], 7);
    tick(30);

    // R11 back to back
    div_int = '0;
    div_frac = '0;
    base = nst;
    run_continuous = 1'b1;
    for (int k = 0; k < 200; k++) begin
      if (nst >= base + 6) break;
      @(negedge clk);
    end
    run_continuous = 1'b0;
    for (int i = 0; i < 5; i++)
      check(st_time[base+i+1] - st_time[base+i] == 3, "R11 back to back",
            st_time[base+i+1] - st_time[base+i], 3);
    tick(10);
    finish_run();
  end
endmodule